// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single timer channel that generates a pulse-width-modulated waveform. Software writes a period value and a compare value into two holding registers. These values reach the active down-counter and comparator only at two moments: while a manual-update bit is held in the control word, or when the counter expires with auto-reload enabled. Values can therefore be changed while the channel runs without producing a glitched period.

The counter decrements once on every clock where the prescaler's tick enable is high. An expiry restarts the waveform low, and the raw waveform goes high when the count reaches the compare value. An invert bit flips the final output. The channel emits a one-clock expiry pulse each time it passes zero while running. Several channels share one control word, and each channel decodes its own four-bit group from that word. The group positions leave a gap after channel 0, and on the last channel the auto-reload bit sits in a different place.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After synchronous reset, pwm_out and expire_pulse are 0, the channel is stopped, all control bits are clear and both holding registers are 0.
- R2: A write with wr_addr equal to 0x0C + 12*CHAN sets the period holding register, and a write with wr_addr equal to 0x10 + 12*CHAN sets the compare holding register. Both keep only the low CNT_W bits of wr_data. A write with wr_addr equal to 0x08 sets the control group. Writes to any other address leave the channel unchanged.
- R3: The control group of channel 0 is wr_data[3:0], and for CHAN >= 1 it is wr_data[4*(CHAN+1)+3 : 4*(CHAN+1)]. Inside a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. On the last channel (CHAN = NUM_CH-1), bit 2 is auto-reload, bit 3 is ignored and the output is never inverted.
- R4: On every clock where manual update is set, both holding registers are copied into the active counter and comparator, the raw waveform is driven low and the channel stays halted. No counting takes place and no expiry pulse is produced during these clocks.
- R5: A write to a holding register leaves the active period and compare values unchanged until the next manual update or auto-reload.
- R6: With start and auto-reload set and a period value N >= 1, each period lasts N+1 ticks. Exactly one expiry pulse occurs per period, and each pulse is one clock long.
- R7: For a compare value C < N, the raw waveform is high for C+1 ticks of each period. pwm_out follows the raw waveform when invert is clear and is high for N-C ticks when invert is set.
- R8: A compare value C >= N, which includes all ones, never matches. pwm_out then stays at the invert bit (100% high with invert set, 0% with invert clear).
- R9: With auto-reload clear, the counter expires once and produces one expiry pulse, then halts until the next manual update. While halted, pwm_out equals the invert bit.
- R10: While start is clear, the counter holds, no expiry pulse occurs and pwm_out equals the invert bit.
- R11: The counter advances only on clocks where tick_en is high, so a tick every second clock doubles every duration in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | DATA_W | Register write data |
| pwm_out | output | 1 | Waveform output after inversion |
| expire_pulse | output | 1 | One-clock pulse when the running counter passes zero |

## Verification
The hardest case to reach from the ports is a change to a holding register that must not take effect until the next reload. This needs a channel that has already loaded the old value and is counting when the new value arrives. The bench arms the channel with a manual update, then rewrites the period register before starting a one-shot run, and times the first expiry pulse against the old period. It then rewrites the buffers during an auto-reload run and measures the new duty only after a reload has taken place. Duty and period are swept over every compare value around each small period, with both polarities and two tick rates, and the expected high-clock counts are computed arithmetically.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    // Decoded view of one channel's control group.
    typedef struct packed {
        logic start;
        logic mupd;
        logic inv;
        logic arld;
    } chan_ctrl_t;

    // What the counter asks the waveform stage to do this clock.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LOAD  = 2'd1,
        EV_STOP  = 2'd2,
        EV_MATCH = 2'd3
    } wave_evt_t;

    localparam int CTRL_WORD_ADDR = 8;
    localparam int BUF_STRIDE     = 12;
    localparam int GROUP_BITS     = 4;

    function automatic int cnt_buf_addr(input int ch);
        return 12 + BUF_STRIDE * ch;
    endfunction

    function automatic int cmp_buf_addr(input int ch);
        return 16 + BUF_STRIDE * ch;
    endfunction

    // Channel 0 sits at the bottom; a one-group gap follows it.
    function automatic int ctrl_group_lsb(input int ch);
        return (ch == 0) ? 0 : GROUP_BITS * (ch + 1);
    endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CHAN   = 1,
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_buf,
    output logic [CNT_W-1:0]  cmp_buf,
    output chan_ctrl_t        ctrl
);
    localparam int GRP_LSB = ctrl_group_lsb(CHAN);
    localparam bit IS_LAST = (CHAN == NUM_CH - 1);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(cnt_buf_addr(CHAN));
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(cmp_buf_addr(CHAN));
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_WORD_ADDR);

    logic [GROUP_BITS-1:0] grp;
    chan_ctrl_t            grp_dec;
    logic                  unused_wr_bits;

    assign grp            = wr_data[GRP_LSB +: GROUP_BITS];
    assign unused_wr_bits = ^wr_data;

    // The last channel has no inverter; its reload flag moves down one bit.
    generate
        if (IS_LAST) begin : g_last_layout
            assign grp_dec = '{start: grp[0], mupd: grp[1], inv: 1'b0, arld: grp[2]};
        end else begin : g_std_layout
            assign grp_dec = '{start: grp[0], mupd: grp[1], inv: grp[2], arld: grp[3]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_buf <= '0;
            cmp_buf <= '0;
            ctrl    <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CNT)  cnt_buf <= wr_data[CNT_W-1:0];
            if (wr_addr == A_CMP)  cmp_buf <= wr_data[CNT_W-1:0];
            if (wr_addr == A_CTRL) ctrl    <= grp_dec;
        end
    end

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  chan_ctrl_t       ctrl,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output wave_evt_t        evt,
    output logic             expire
);
    logic             halted;
    logic             run;
    logic             at_zero;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_dec = cnt_q - CNT_W'(1);
    assign at_zero = (cnt_q == '0);
    assign run     = ctrl.start && tick_en && !halted && !ctrl.mupd;

    always_comb begin
        evt = EV_NONE;
        if (ctrl.mupd)
            evt = EV_LOAD;
        else if (run && at_zero)
            evt = ctrl.arld ? EV_LOAD : EV_STOP;
        else if (run && (cnt_dec == cmp_q))
            evt = EV_MATCH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            halted <= 1'b1;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (ctrl.mupd) begin
                cnt_q  <= cnt_buf;
                cmp_q  <= cmp_buf;
                halted <= 1'b0;
            end else if (run) begin
                if (at_zero) begin
                    expire <= 1'b1;
                    if (ctrl.arld) begin
                        cnt_q <= cnt_buf;
                        cmp_q <= cmp_buf;
                    end else begin
                        halted <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_dec;
                end
            end
        end
    end

    // R4: a manual-update clock copies both holding registers.
    a_r4_manual_load: assert property (@(posedge clk) disable iff (rst)
        ctrl.mupd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));

    // R10: with start clear and no update, the count does not move.
    a_r10_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.start && !ctrl.mupd) |=> ($stable(cnt_q) && !expire));

    // R11: no tick, no movement and no expiry.
    a_r11_tick_gate: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !ctrl.mupd) |=> ($stable(cnt_q) && !expire));

    // R9: a halted channel stays put until the next manual update.
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (halted && !ctrl.mupd) |=> ($stable(cnt_q) && !expire));

endmodule

// File: rtl/pwm_chan_wavegen.sv
module pwm_chan_wavegen
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wave_evt_t        evt,
    input  chan_ctrl_t       ctrl,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cmp_q,
    output logic             pwm_out
);
    logic raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
        end else begin
            unique case (evt)
                EV_LOAD, EV_STOP: raw_q <= 1'b0;
                EV_MATCH:         raw_q <= 1'b1;
                default:          raw_q <= raw_q;
            endcase
        end
    end

    // Stopped channels sit at the inactive level, then polarity applies.
    assign pwm_out = (ctrl.start & raw_q) ^ ctrl.inv;

    // R7: the raw waveform only rises when the count meets the compare value.
    a_r7_rise_at_match: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> (cnt_q == cmp_q));

    // R10: while stopped, the output equals the polarity bit.
    a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
        !ctrl.start |-> (pwm_out == ctrl.inv));

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CHAN   = 1,
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              expire_pulse
);
    chan_ctrl_t       ctrl;
    wave_evt_t        evt;
    logic [CNT_W-1:0] cnt_buf;
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;

    pwm_chan_regs #(
        .CNT_W (CNT_W),
        .CHAN  (CHAN),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cnt_buf(cnt_buf),
        .cmp_buf(cmp_buf),
        .ctrl   (ctrl)
    );

    pwm_chan_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .ctrl   (ctrl),
        .cnt_buf(cnt_buf),
        .cmp_buf(cmp_buf),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .evt    (evt),
        .expire (expire_pulse)
    );

    pwm_chan_wavegen #(
        .CNT_W(CNT_W)
    ) u_wave (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .ctrl   (ctrl),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .pwm_out(pwm_out)
    );

endmodule

// File: tb/sim_pwm_dbuf_channel.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_channel;
    localparam logic [31:0] START0 = 32'h1 << 8;
    localparam logic [31:0] MUPD0  = 32'h1 << 9;
    localparam logic [31:0] INV0   = 32'h1 << 10;
    localparam logic [31:0] ARLD0  = 32'h1 << 11;
    localparam logic [31:0] START1 = 32'h1 << 20;
    localparam logic [31:0] MUPD1  = 32'h1 << 21;
    localparam logic [31:0] ARLD1  = 32'h1 << 22;
    localparam logic [31:0] BIT23  = 32'h1 << 23;
    localparam logic [7:0]  A_CTRL = 8'h08;
    localparam logic [7:0]  A_CNT0 = 8'h18;
    localparam logic [7:0]  A_CMP0 = 8'h1C;
    localparam logic [7:0]  A_CNT1 = 8'h3C;
    localparam logic [7:0]  A_CMP1 = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pwm0, exp0, pwm1, exp1;
    int          div_sel = 1;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    always @(negedge clk) tick_en = (div_sel == 1) ? 1'b1 : ~tick_en;

    pwm_dbuf_channel #(.CNT_W(16), .CHAN(1)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm0), .expire_pulse(exp0));

    pwm_dbuf_channel #(.CNT_W(16), .CHAN(4)) u1 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm1), .expire_pulse(exp1));

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input bit which, input int cyc,
                           output int ones, output int pulses, output int dbl);
        bit prev = 1'b0;
        ones = 0; pulses = 0; dbl = 0;
        for (int i = 0; i < cyc; i++) begin
            bit p, e;
            @(negedge clk);
            p = which ? pwm1 : pwm0;
            e = which ? exp1 : exp0;
            ones += int'(p);
            pulses += int'(e);
            if (e && prev) dbl++;
            prev = e;
        end
    endtask

    task automatic arm0(input int n, input int c, input bit inv);
        wr(A_CNT0, 32'(n));
        wr(A_CMP0, 32'(c));
        wr(A_CTRL, MUPD0 | (inv ? INV0 : 32'h0));
        wr(A_CTRL, inv ? INV0 : 32'h0);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ones, pulses, dbl, cnt;
        repeat (3) @(negedge clk);
        chk("R1 pwm_out in reset", int'(pwm0), 0);
        chk("R1 expire in reset", int'(exp0), 0);
        rst = 1'b0;
        measure(0, 10, ones, pulses, dbl);
        chk("R1 idle output after reset", ones, 0);
        chk("R1 no expiry after reset", pulses, 0);

        // R6 R7 R8 R11: duty and period sweep
        for (int dv = 1; dv <= 2; dv++) begin
            div_sel = dv;
            for (int n = 1; n <= 6; n++) begin
                for (int ci = 0; ci <= n + 2; ci++) begin
                    for (int inv = 0; inv <= 1; inv++) begin
                        int c, exp_ones;
                        c = (ci == n + 2) ? 65535 : ci;
                        arm0(n, c, inv[0]);
                        wr(A_CTRL, START0 | ARLD0 | (inv[0] ? INV0 : 32'h0));
                        measure(0, 3 * (n + 1) * dv, ones, pulses, dbl);
                        measure(0, 4 * (n + 1) * dv, ones, pulses, dbl);
                        if (c < n) exp_ones = 4 * dv * (inv[0] ? (n - c) : (c + 1));
                        else       exp_ones = 4 * dv * (inv[0] ? (n + 1) : 0);
                        chk($sformatf("%s duty n=%0d c=%0d inv=%0d div=%0d",
                            (c < n) ? "R7 R11" : "R8", n, c, inv, dv), ones, exp_ones);
                        chk($sformatf("R6 R11 period n=%0d c=%0d div=%0d", n, c, dv), pulses, 4);
                        chk($sformatf("R6 one-clock pulse n=%0d", n), dbl, 0);
                    end
                end
            end
        end
        div_sel = 1;
        repeat (2) @(negedge clk);

        // R5 R9: buffer rewritten after the load; one-shot uses the old period
        arm0(4, 1, 1'b1);
        wr(A_CNT0, 32'd9);
        wr(A_CTRL, START0 | INV0);
        cnt = 0;
        for (int i = 1; i <= 50; i++) begin
            @(negedge clk);
            if (exp0) begin cnt = i; break; end
        end
        chk("R5 R9 first expiry uses loaded period", cnt, 5);
        measure(0, 30, ones, pulses, dbl);
        chk("R9 no expiry after one-shot", pulses, 0);
        chk("R9 halted output at invert level", ones, 30);

        // R4 R5: manual update adopts the new buffer value (period 10)
        wr(A_CTRL, MUPD0 | INV0);
        wr(A_CTRL, START0 | ARLD0 | INV0);
        measure(0, 20, ones, pulses, dbl);
        measure(0, 40, ones, pulses, dbl);
        chk("R4 manual update loads new period", pulses, 4);
        chk("R4 duty after manual update", ones, 4 * (9 - 1));

        // R5: rewrite while running, taken at the next reload
        wr(A_CNT0, 32'd2);
        wr(A_CMP0, 32'd0);
        measure(0, 30, ones, pulses, dbl);
        measure(0, 30, ones, pulses, dbl);
        chk("R5 auto-reload adopts new period", pulses, 10);
        chk("R5 auto-reload adopts new compare", ones, 20);

        // R4: held manual update suspends counting
        wr(A_CTRL, START0 | ARLD0 | MUPD0 | INV0);
        measure(0, 20, ones, pulses, dbl);
        chk("R4 no expiry while update held", pulses, 0);
        chk("R4 raw low while update held", ones, 20);

        // R10: start clear holds the channel at the invert level
        for (int inv = 0; inv <= 1; inv++) begin
            arm0(3, 1, inv[0]);
            wr(A_CTRL, ARLD0 | (inv[0] ? INV0 : 32'h0));
            measure(0, 30, ones, pulses, dbl);
            chk($sformatf("R10 stopped no expiry inv=%0d", inv), pulses, 0);
            chk($sformatf("R10 stopped level inv=%0d", inv), ones, inv ? 30 : 0);
        end

        // R2: foreign addresses ignored, data truncated to CNT_W
        arm0(5, 2, 1'b1);
        wr(8'h0C, 32'd2);
        wr(8'h10, 32'd0);
        wr(8'h24, 32'd1);
        wr(A_CTRL, MUPD0 | INV0);
        wr(A_CTRL, START0 | ARLD0 | INV0);
        measure(0, 24, ones, pulses, dbl);
        measure(0, 24, ones, pulses, dbl);
        chk("R2 other channel writes ignored (period)", pulses, 4);
        chk("R2 other channel writes ignored (duty)", ones, 12);
        wr(A_CNT0, 32'h0007_0003);
        wr(A_CMP0, 32'h0005_0001);
        wr(A_CTRL, MUPD0 | INV0);
        wr(A_CTRL, START0 | ARLD0 | INV0);
        measure(0, 16, ones, pulses, dbl);
        measure(0, 16, ones, pulses, dbl);
        chk("R2 truncated period", pulses, 4);
        chk("R2 truncated compare", ones, 8);

        // R3: bits outside channel 1's group leave it stopped
        arm0(2, 0, 1'b0);
        wr(A_CTRL, 32'h0000_00FF);
        measure(0, 20, ones, pulses, dbl);
        chk("R3 channel 0 group ignored (expiry)", pulses, 0);
        chk("R3 channel 0 group ignored (level)", ones, 0);

        // R3: last channel decodes reload at group bit 2, never inverts
        wr(A_CNT1, 32'd3);
        wr(A_CMP1, 32'd0);
        wr(A_CTRL, MUPD1);
        wr(A_CTRL, START1 | ARLD1);
        measure(1, 16, ones, pulses, dbl);
        measure(1, 16, ones, pulses, dbl);
        chk("R3 last channel reload at bit 22", pulses, 4);
        chk("R3 last channel not inverted", ones, 4);
        wr(A_CTRL, MUPD1);
        wr(A_CTRL, START1 | BIT23);
        measure(1, 40, ones, pulses, dbl);
        chk("R3 last channel bit 23 is not reload", pulses, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule